// File: doc/BRIEF.md
# Latched Fault Collector with Escalation Watchdog

This block gathers single-cycle critical fault strobes from around the chip into sticky flags and turns them into one non-maskable interrupt pulse toward the CPU. Each fault bit that is caught is also written into a mirror register. The mirror is kept through a system reset, so the cause can still be read after the chip restarts. Software reads the flags over a small register bus, clears them with write-one-to-clear, and can set them on purpose for testing.

Once the block is armed, any latched fault starts an escalation counter. If software does not clear every fault before the counter reaches a programmable limit, the block raises a one-cycle system reset request. Writes to the registers that change behaviour are accepted only while an unlock input is high.

Register offsets (4-bit word address): 0 arm control (bit 0), 1 fault flags, 2 clear strobe, 3 force strobe, 4 escalation count, 5 escalation limit, 6 mirror flags. Fault bits are 15..1 except bit 11, which is reserved. Bit 0 of the flag register is the summary interrupt flag.

Top module: `fault_nmi_hub`

## Requirements
- R1: After power-on reset the arm bit, flags, mirror and count all read 0, the limit reads FFFFh, and `nmi_pulse` and `rst_req` are low.
- R2: Writing 1 to bit 0 of offset 0 arms the block. Writing 0 does nothing. Only a system or power-on reset disarms it.
- R3: A high `fault_in[i]` for i in 15..1, i not 11, is sampled at a clock edge and sets flag bit i, and the bit stays set whether or not the block is armed. `fault_in` bits 0 and 11 are ignored, and flag bit 11 always reads 0.
- R4: Writing 1 to a bit at offset 2 clears that flag bit and its mirror bit. Written zeros have no effect. Offsets 2 and 3 always read 0.
- R5: If a fault input sets a bit in the same cycle that a clear write targets it, the bit stays set.
- R6: Writing 1 to a fault bit at offset 3 sets that bit in both the flag and mirror registers. Bit 0 (summary) cannot be forced.
- R7: While armed with any fault flag set, the summary bit sets and `nmi_pulse` is high for exactly one cycle. This happens two clock edges after the fault is sampled. No further pulse follows until software clears the summary bit. If software clears the summary bit while faults remain, the summary bit sets again and a new pulse comes one cycle later.
- R8: The 16-bit count rises by one per clock while armed with any fault flag set. Otherwise it is forced to 0.
- R9: When the count equals the limit, `rst_req` pulses for one cycle and the count returns to 0. Counting resumes if faults remain. With limit P and a fault sampled at edge E1, the pulse appears after edge E(P+2).
- R10: The limit at offset 5 is read/write and resets to FFFFh on system reset.
- R11: The mirror follows every set, force and clear of the fault flags. A system reset leaves it intact, and only a power-on reset clears it.
- R12: Writes to offsets 0, 2, 3 and 5 take effect only while `unlock` is high.
- R13: Offsets 7 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low system reset |
| por_rst_n | input | 1 | Active-low power-on reset, also resets all system state |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| unlock | input | 1 | Write-protect release |
| fault_in | input | 16 | Fault strobes, bit i for flag i |
| nmi_pulse | output | 1 | One-cycle interrupt pulse |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two events can land in the same cycle and must be resolved: a hardware fault setting a flag, and software clearing that same flag. The bench drives a fault strobe on the very clock edge where a clear write hits the same bit. It then reads the flag back and expects it to still be set. A second pairing is clearing the summary bit while a fault is still pending. The bench expects the summary bit to read 0 for one cycle, and then expects a fresh interrupt pulse on the following cycle.

// File: rtl/fnh_pkg.sv
package fnh_pkg;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam logic [DW-1:0] FAULT_MASK = 16'hF7FE;
    localparam logic [DW-1:0] LIMIT_RST  = 16'hFFFF;

    localparam logic [AW-1:0] OFS_ARM   = 4'd0;
    localparam logic [AW-1:0] OFS_FLAG  = 4'd1;
    localparam logic [AW-1:0] OFS_CLR   = 4'd2;
    localparam logic [AW-1:0] OFS_FRC   = 4'd3;
    localparam logic [AW-1:0] OFS_CNT   = 4'd4;
    localparam logic [AW-1:0] OFS_LIMIT = 4'd5;
    localparam logic [AW-1:0] OFS_SHD   = 4'd6;

    typedef struct packed {
        logic          armed;
        logic [DW-1:0] limit;
    } ctl_state_t;

    typedef struct packed {
        logic [DW-1:0] flt;
        logic          sum;
        logic          nmi;
    } flag_state_t;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          fire;
    } wd_state_t;
endpackage

// File: rtl/fnh_regfile.sv
module fnh_regfile
    import fnh_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW,
    parameter logic [DATA_W-1:0] LIMIT_INIT = LIMIT_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlock,
    input  logic [DATA_W-1:0] flag_vec,
    input  logic [DATA_W-1:0] shd_vec,
    input  logic [DATA_W-1:0] cnt,
    output logic              armed,
    output logic [DATA_W-1:0] limit,
    output logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] frc_vec,
    output logic [DATA_W-1:0] rdata
);
    ctl_state_t st_d, st_q;
    logic       wr_ok;

    always_comb begin
        wr_ok   = we & unlock;
        st_d    = st_q;
        clr_vec = '0;
        frc_vec = '0;
        if (wr_ok) begin
            case (addr)
                OFS_ARM:   st_d.armed = st_q.armed | wdata[0];
                OFS_CLR:   clr_vec    = wdata;
                OFS_FRC:   frc_vec    = wdata;
                OFS_LIMIT: st_d.limit = wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_ARM:   rdata = {{(DATA_W-1){1'b0}}, st_q.armed};
            OFS_FLAG:  rdata = flag_vec;
            OFS_CNT:   rdata = cnt;
            OFS_LIMIT: rdata = st_q.limit;
            OFS_SHD:   rdata = shd_vec;
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b0;
            st_q.limit <= LIMIT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign limit = st_q.limit;
endmodule

// File: rtl/fnh_flag_bank.sv
module fnh_flag_bank
    import fnh_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter logic [DATA_W-1:0] MASK = FAULT_MASK
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              por_rst_n,
    input  logic              armed,
    input  logic [DATA_W-1:0] fault_in,
    input  logic [DATA_W-1:0] clr_vec,
    input  logic [DATA_W-1:0] frc_vec,
    output logic [DATA_W-1:0] flag_vec,
    output logic [DATA_W-1:0] shd_vec,
    output logic              any_fault,
    output logic              nmi_pulse
);
    flag_state_t       st_d, st_q;
    logic [DATA_W-1:0] shd_d, shd_q;
    logic [DATA_W-1:0] hw_set;
    logic [DATA_W-1:0] set_vec;
    logic              sum_set;

    for (genvar i = 0; i < DATA_W; i++) begin : g_src
        if (MASK[i]) begin : g_live
            assign hw_set[i] = fault_in[i];
        end else begin : g_rsvd
            assign hw_set[i] = fault_in[i] & 1'b0;
        end
    end

    always_comb begin
        set_vec   = (hw_set | frc_vec) & MASK;
        any_fault = |(st_q.flt & MASK);
        sum_set   = armed & any_fault & ~st_q.sum;
        st_d.flt  = ((st_q.flt & ~clr_vec) | set_vec) & MASK;
        st_d.sum  = (st_q.sum & ~clr_vec[0]) | sum_set;
        st_d.nmi  = sum_set;
        shd_d     = ((shd_q & ~clr_vec) | set_vec) & MASK;
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            shd_q <= '0;
        end else begin
            shd_q <= shd_d;
        end
    end

    assign flag_vec  = st_q.flt | {{(DATA_W-1){1'b0}}, st_q.sum};
    assign shd_vec   = shd_q;
    assign nmi_pulse = st_q.nmi;
endmodule

// File: rtl/fnh_watchdog.sv
module fnh_watchdog
    import fnh_pkg::*;
#(
    parameter int CNT_W = DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    wd_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit       = (st_q.cnt == limit);
        st_d.fire = active & hit;
        if (!active || hit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign fire = st_q.fire;
endmodule

// File: rtl/fault_nmi_hub.sv
module fault_nmi_hub
    import fnh_pkg::*;
(
    input  logic          clk,
    input  logic          sys_rst_n,
    input  logic          por_rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          unlock,
    input  logic [DW-1:0] fault_in,
    output logic          nmi_pulse,
    output logic          rst_req
);
    logic          sys_any_n;
    logic          cfg_en;
    logic          any_fault;
    logic [DW-1:0] limit;
    logic [DW-1:0] clr_vec;
    logic [DW-1:0] frc_vec;
    logic [DW-1:0] flag_vec;
    logic [DW-1:0] shd_vec;
    logic [DW-1:0] wd_cnt;

    assign sys_any_n = sys_rst_n & por_rst_n;

    fnh_regfile #(.DATA_W(DW), .ADDR_W(AW), .LIMIT_INIT(LIMIT_RST)) u_regs (
        .clk      (clk),
        .rst_n    (sys_any_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .unlock   (unlock),
        .flag_vec (flag_vec),
        .shd_vec  (shd_vec),
        .cnt      (wd_cnt),
        .armed    (cfg_en),
        .limit    (limit),
        .clr_vec  (clr_vec),
        .frc_vec  (frc_vec),
        .rdata    (bus_rdata)
    );

    fnh_flag_bank #(.DATA_W(DW), .MASK(FAULT_MASK)) u_flags (
        .clk       (clk),
        .sys_rst_n (sys_any_n),
        .por_rst_n (por_rst_n),
        .armed     (cfg_en),
        .fault_in  (fault_in),
        .clr_vec   (clr_vec),
        .frc_vec   (frc_vec),
        .flag_vec  (flag_vec),
        .shd_vec   (shd_vec),
        .any_fault (any_fault),
        .nmi_pulse (nmi_pulse)
    );

    fnh_watchdog #(.CNT_W(DW)) u_wd (
        .clk    (clk),
        .rst_n  (sys_any_n),
        .active (cfg_en & any_fault),
        .limit  (limit),
        .cnt    (wd_cnt),
        .fire   (rst_req)
    );
endmodule

// File: rtl/fnh_checker.sv
module fnh_checker
    import fnh_pkg::*;
(
    input logic          clk,
    input logic          sys_rst_n,
    input logic          por_rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [DW-1:0] bus_rdata,
    input logic          unlock,
    input logic          nmi_pulse,
    input logic          rst_req,
    input logic          cfg_en,
    input logic [DW-1:0] flag_vec,
    input logic [DW-1:0] shd_vec,
    input logic [DW-1:0] wd_cnt
);
    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
        nmi_pulse |=> !nmi_pulse); // R7
    AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
        (bus_addr == OFS_CLR || bus_addr == OFS_FRC) |-> bus_rdata == '0); // R4
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
        cfg_en |=> cfg_en); // R2
    AST_WD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
        ((flag_vec & FAULT_MASK) == '0) |=> wd_cnt == '0); // R8
    AST_WD_WRAP: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
        rst_req |-> wd_cnt == '0); // R9
    AST_SHADOW_COVERS: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
        (flag_vec & FAULT_MASK & ~shd_vec) == '0); // R11
    AST_LOCKED_ARM: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
        (bus_we && !unlock && bus_addr == OFS_ARM && !cfg_en) |=> !cfg_en); // R12
    AST_RSVD_BIT11: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
        !flag_vec[11] && !shd_vec[11]); // R3
endmodule

bind fault_nmi_hub fnh_checker u_chk (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .por_rst_n (por_rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .unlock    (unlock),
    .nmi_pulse (nmi_pulse),
    .rst_req   (rst_req),
    .cfg_en    (cfg_en),
    .flag_vec  (flag_vec),
    .shd_vec   (shd_vec),
    .wd_cnt    (wd_cnt)
);

// File: tb/sim_fault_nmi_hub.sv
`timescale 1ns/1ps
module sim_fault_nmi_hub;
    logic        clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        por_rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        unlock = 1'b0;
    logic [15:0] fault_in = '0;
    logic        nmi_pulse;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fault_nmi_hub u0 (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .por_rst_n (por_rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .unlock    (unlock),
        .fault_in  (fault_in),
        .nmi_pulse (nmi_pulse),
        .rst_req   (rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, {16'h0, v}, {16'h0, exp});
    endtask

    task automatic pulse_fault(input logic [15:0] f);
        @(negedge clk);
        fault_in = f;
        @(negedge clk);
        fault_in = '0;
    endtask

    task automatic t_reset;
        rdchk("R1 arm", 4'd0, 16'h0000);
        rdchk("R1 flags", 4'd1, 16'h0000);
        rdchk("R1 count", 4'd4, 16'h0000);
        rdchk("R10 limit reset", 4'd5, 16'hFFFF);
        rdchk("R1 mirror", 4'd6, 16'h0000);
        chk("R1 nmi", {31'h0, nmi_pulse}, 32'h0);
        chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_lock;
        unlock = 1'b0;
        wr(4'd0, 16'h0001);
        wr(4'd3, 16'h0010);
        wr(4'd5, 16'h0005);
        rdchk("R12 arm locked", 4'd0, 16'h0000);
        rdchk("R12 force locked", 4'd1, 16'h0000);
        rdchk("R12 limit locked", 4'd5, 16'hFFFF);
        unlock = 1'b1;
    endtask

    task automatic t_reserved;
        wr(4'd9, 16'hFFFF);
        wr(4'd7, 16'hFFFF);
        rdchk("R13 read 7", 4'd7, 16'h0000);
        rdchk("R13 read 9", 4'd9, 16'h0000);
        rdchk("R13 read 15", 4'd15, 16'h0000);
        rdchk("R13 no arm", 4'd0, 16'h0000);
        rdchk("R13 no flags", 4'd1, 16'h0000);
    endtask

    task automatic t_latch;
        pulse_fault(16'hFFFF);
        repeat (3) @(negedge clk);
        rdchk("R3 latch mask", 4'd1, 16'hF7FE);
        rdchk("R11 mirror set", 4'd6, 16'hF7FE);
        chk("R7 no nmi unarmed", {31'h0, nmi_pulse}, 32'h0);
        rdchk("R8 no count unarmed", 4'd4, 16'h0000);
        wr(4'd2, 16'h0000);
        rdchk("R4 zero clear ignored", 4'd1, 16'hF7FE);
        rdchk("R4 clr reads zero", 4'd2, 16'h0000);
        rdchk("R4 frc reads zero", 4'd3, 16'h0000);
        wr(4'd2, 16'h0F00);
        rdchk("R4 partial clear", 4'd1, 16'hF0FE);
        rdchk("R11 mirror clear", 4'd6, 16'hF0FE);
        wr(4'd2, 16'hFFFF);
        rdchk("R4 full clear", 4'd1, 16'h0000);
    endtask

    task automatic t_force;
        wr(4'd3, 16'h8001);
        rdchk("R6 force flag", 4'd1, 16'h8000);
        rdchk("R6 force mirror", 4'd6, 16'h8000);
        wr(4'd2, 16'hFFFF);
        rdchk("R6 cleared", 4'd6, 16'h0000);
    endtask

    task automatic t_setwins;
        @(negedge clk);
        fault_in  = 16'h0020;
        bus_addr  = 4'd2;
        bus_wdata = 16'h0020;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        fault_in  = '0;
        rdchk("R5 set wins", 4'd1, 16'h0020);
        wr(4'd2, 16'h0020);
        rdchk("R5 later clear", 4'd1, 16'h0000);
    endtask

    task automatic t_enable;
        wr(4'd0, 16'h0000);
        rdchk("R2 zero no arm", 4'd0, 16'h0000);
        wr(4'd0, 16'h0001);
        rdchk("R2 arm", 4'd0, 16'h0001);
        wr(4'd0, 16'h0000);
        rdchk("R2 sticky", 4'd0, 16'h0001);
    endtask

    task automatic t_nmi;
        logic seen;
        @(negedge clk);
        fault_in = 16'h0004;
        @(negedge clk);
        fault_in = '0;
        chk("R7 no early pulse", {31'h0, nmi_pulse}, 32'h0);
        rdchk("R7 flag only", 4'd1, 16'h0004);
        @(negedge clk);
        chk("R7 pulse", {31'h0, nmi_pulse}, 32'h1);
        rdchk("R7 summary set", 4'd1, 16'h0005);
        @(negedge clk);
        chk("R7 pulse ends", {31'h0, nmi_pulse}, 32'h0);
        pulse_fault(16'h0040);
        seen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            seen |= nmi_pulse;
        end
        chk("R7 no repeat pulse", {31'h0, seen}, 32'h0);
        wr(4'd2, 16'h0001);
        rdchk("R7 summary cleared", 4'd1, 16'h0044);
        chk("R7 no pulse yet", {31'h0, nmi_pulse}, 32'h0);
        @(negedge clk);
        chk("R7 repulse", {31'h0, nmi_pulse}, 32'h1);
        rdchk("R7 summary again", 4'd1, 16'h0045);
        wr(4'd2, 16'h0044);
        wr(4'd2, 16'h0001);
        seen = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            seen |= nmi_pulse;
        end
        chk("R7 quiet after clear", {31'h0, seen}, 32'h0);
        rdchk("R7 all clear", 4'd1, 16'h0000);
        rdchk("R8 idle zero", 4'd4, 16'h0000);
    endtask

    task automatic t_wdog;
        logic [15:0] exp;
        logic [15:0] v;
        wr(4'd5, 16'h0005);
        rdchk("R10 limit write", 4'd5, 16'h0005);
        bus_addr = 4'd4;
        @(negedge clk);
        fault_in = 16'h0008;
        @(negedge clk);
        fault_in = '0;
        for (int k = 1; k <= 9; k++) begin
            if (k > 1) @(negedge clk);
            if (k == 1 || k == 7) exp = 16'h0;
            else if (k < 7) exp = 16'(k - 1);
            else exp = 16'(k - 7);
            rd(4'd4, v);
            chk("R8 count", {16'h0, v}, {16'h0, exp});
            chk("R9 reset pulse", {31'h0, rst_req}, {31'h0, (k == 7)});
        end
        wr(4'd2, 16'h0009);
        @(negedge clk);
        rdchk("R8 stops after clear", 4'd4, 16'h0000);
        chk("R9 no pulse", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_sysrst;
        wr(4'd3, 16'h1000);
        rdchk("R11 mirror forced", 4'd6, 16'h1000);
        @(negedge clk);
        sys_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        sys_rst_n = 1'b1;
        @(negedge clk);
        rdchk("R11 flags reset", 4'd1, 16'h0000);
        rdchk("R2 disarmed by reset", 4'd0, 16'h0000);
        rdchk("R10 limit restored", 4'd5, 16'hFFFF);
        rdchk("R11 mirror kept", 4'd6, 16'h1000);
        por_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        por_rst_n = 1'b1;
        @(negedge clk);
        rdchk("R11 mirror power-on clear", 4'd6, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        por_rst_n = 1'b1;
        sys_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_reserved();
        t_latch();
        t_force();
        t_setwins();
        t_enable();
        t_nmi();
        t_wdog();
        t_sysrst();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog timeout actual=running expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule